// File: doc/BRIEF.md
# Clock Recovery Point Generator

This block produces timestamp points for adaptive clock recovery. A chosen reference event advances a 32-bit event counter. A second 32-bit counter counts every cycle of the local master clock. The reference is the arrival or loss pulse of one of two cell channels, the rising edge of an alternate reference input, or the block's own fractional-divider tick. A point pairs the two counts. Points are thinned by a programmable decimation factor. Each kept point is written as two words through a plain memory write port, and a recovery algorithm elsewhere reads them.

A loss pulse advances the event counter in the same way as an arrival pulse. A single missing cell therefore still leaves the count correct. The fractional divider turns a 32-bit integer and a 16-bit fraction into a precise clock enable. A sticky timeout flag reports that the reference has gone quiet for longer than a programmable number of master cycles.

Top module: `ts_point_gen`

## Requirements
- R1: `refSel` picks the reference: 0 = channel A pulses, 1 = channel B pulses, 2 = rising edge of `altRef`, 3 = the divider tick `pclkTick`. Pulses of a source that is not selected do not move the event count and produce no point.
- R2: In each cycle, the event count rises by the number of asserted pulses (valid and lost) of the selected channel. That number is 0, 1 or 2, so a lost cell is compensated.
- R3: The master count rises by one on every clock after reset. A point's master word is the master count in the cycle the event is presented, so two points' master words differ by the number of cycles between their events.
- R4: A kept point is written in the two cycles after its event. The first word is the event count including that event, at the write pointer. The second word is the master count, at the pointer plus one. The pointer starts at 0 and wraps modulo 2^AW.
- R5: With a decimation value N >= 2, only every Nth event is kept. A value of 0 or 1 keeps every event.
- R6: An event presented in a cycle where a point's first word is being written is counted but produces no point. An event in the cycle of the second word does produce a point.
- R7: `pclkTick` stays low until a divisor is loaded with `divLoad`. After a load with integer I and fraction F, the periods are I cycles, plus one extra cycle whenever the 16-bit fraction accumulator carries. For I=4 and F=0x8000, ticks appear after 3, 7, 12, 16 and 21 clock edges counted from the load edge.
- R8: `timeoutFlag` rises one cycle after the number of cycles since the last selected event exceeds `toLimit`. With limit 10 and an event at edge k, it is first high after edge k+12. It stays high, even across new events, until `toClear`.
- R9: After reset, `memWe`, `pclkTick` and `timeoutFlag` are low.
- R10: With `refSel` = 2, holding `altRef` high for several cycles yields exactly one event, at its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| refSel | input | 2 | Reference source select |
| validA | input | 1 | Channel A cell arrival pulse |
| lostA | input | 1 | Channel A single cell loss pulse |
| validB | input | 1 | Channel B cell arrival pulse |
| lostB | input | 1 | Channel B single cell loss pulse |
| altRef | input | 1 | Alternate reference level (already synchronous) |
| decim | input | 16 | Keep one point per this many events |
| divInt | input | 32 | Divider integer part |
| divFrac | input | 16 | Divider fractional part |
| divLoad | input | 1 | Transfer divisor into the active divider |
| toLimit | input | 32 | Idle cycles allowed before timeout |
| toClear | input | 1 | Clear the timeout flag |
| pclkTick | output | 1 | Precise local clock enable |
| timeoutFlag | output | 1 | Sticky reference-loss flag |
| memWe | output | 1 | Point memory write enable |
| memAddr | output | 4 | Point memory word address |
| memData | output | 32 | Point memory write data |

## Verification
Single arrival pulses, arrival-plus-loss pulses and lone loss pulses on the selected channel separate correct compensation from plain pulse counting. The same pulses on the unselected channel show that selection really gates the count. Bursts of back-to-back events tell the one-cycle drop window apart from the cycle in which a new point may already be taken. A long-held alternate level separates edge detection from level counting. The divider is run with a half fraction, so that a missing or misplaced carry cycle moves a tick position. Enough points are taken for the pointer to wrap.

// File: rtl/tspg_pkg.sv
package tspg_pkg;
  typedef enum logic [1:0] {REF_A = 2'd0, REF_B = 2'd1, REF_ALT = 2'd2, REF_PCLK = 2'd3} refsel_e;

  typedef struct packed {
    logic take;   // capture snapshot this edge
    logic wrEvt;  // writing event word this cycle
    logic wrMst;  // writing master word this cycle
  } strobe_t;
endpackage

// File: rtl/tspg_fracdiv.sv
module tspg_fracdiv #(
  parameter int CW = 32,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] divInt,
  input  logic [FW-1:0] divFrac,
  input  logic          divLoad,
  output logic          tick
);
  logic [CW-1:0] activeInt;
  logic [FW-1:0] activeFrac;
  logic [FW-1:0] acc;
  logic [CW-1:0] cnt;
  logic [FW:0]   sum;

  assign sum  = {1'b0, acc} + {1'b0, activeFrac};
  assign tick = (activeInt != '0) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeInt  <= '0;
      activeFrac <= '0;
      acc        <= '0;
      cnt        <= '0;
    end else if (divLoad) begin
      activeInt  <= divInt;
      activeFrac <= divFrac;
      acc        <= '0;
      cnt        <= divInt - CW'(1);
    end else if (tick) begin
      acc <= sum[FW-1:0];
      cnt <= activeInt - CW'(1) + CW'(sum[FW]);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  // R7: a period of two or more cycles never gives adjacent ticks
  assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tick && activeInt > CW'(1) && !divLoad) |=> !tick);
endmodule

// File: rtl/tspg_ctrl.sv
module tspg_ctrl
  import tspg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    refSel,
  input  logic          validA,
  input  logic          lostA,
  input  logic          validB,
  input  logic          lostB,
  input  logic          altRef,
  input  logic          pclkTick,
  input  logic [DW-1:0] decim,
  output logic [1:0]    evtInc,
  output logic          evtHit,
  output strobe_t       strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_EVT, ST_MST} wr_state_e;

  wr_state_e     state;
  logic          altQ;
  logic          altEdge;
  logic [DW-1:0] decimCnt;
  logic          keepPt;

  assign altEdge = altRef & ~altQ;

  always_comb begin
    unique case (refsel_e'(refSel))
      REF_A:    evtInc = {1'b0, validA} + {1'b0, lostA};
      REF_B:    evtInc = {1'b0, validB} + {1'b0, lostB};
      REF_ALT:  evtInc = {1'b0, altEdge};
      REF_PCLK: evtInc = {1'b0, pclkTick};
      default:  evtInc = 2'd0;
    endcase
  end

  assign evtHit = (evtInc != 2'd0);
  assign keepPt = evtHit && ((decim <= DW'(1)) || (decimCnt >= decim - DW'(1)));

  assign strb.take  = keepPt && (state != ST_EVT);
  assign strb.wrEvt = (state == ST_EVT);
  assign strb.wrMst = (state == ST_MST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      altQ     <= 1'b0;
      decimCnt <= '0;
      state    <= ST_IDLE;
    end else begin
      altQ <= altRef;
      if (evtHit) decimCnt <= keepPt ? '0 : decimCnt + DW'(1);
      if (strb.take)            state <= ST_EVT;
      else if (state == ST_EVT) state <= ST_MST;
      else                      state <= ST_IDLE;
    end
  end

  // R4: the event word is always followed by the master word
  assert_word_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEvt |=> strb.wrMst);
  // R6: a kept event during the first word write starts no new point
  assert_drop_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    (keepPt && state == ST_EVT) |=> (state == ST_MST));
  // R10: a held alternate level gives no second event
  assert_alt_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    (refsel_e'(refSel) == REF_ALT && altEdge) |=> !altEdge);
endmodule

// File: rtl/tspg_datapath.sv
module tspg_datapath
  import tspg_pkg::*;
#(
  parameter int CW = 32,
  parameter int FW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    evtInc,
  input  logic          evtHit,
  input  strobe_t       strb,
  input  logic [CW-1:0] divInt,
  input  logic [FW-1:0] divFrac,
  input  logic          divLoad,
  input  logic [CW-1:0] toLimit,
  input  logic          toClear,
  output logic          pclkTick,
  output logic          timeoutFlag,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [CW-1:0] memData
);
  localparam logic [CW-1:0] IDLE_MAX = '1;

  logic [CW-1:0] evtCnt;
  logic [CW-1:0] mstCnt;
  logic [CW-1:0] snapEvt;
  logic [CW-1:0] snapMst;
  logic [CW-1:0] idleCnt;
  logic [AW-1:0] wrPtr;
  logic [CW-1:0] evtNext;

  tspg_fracdiv #(.CW(CW), .FW(FW)) uDiv (
    .clk(clk), .rstN(rstN), .divInt(divInt), .divFrac(divFrac),
    .divLoad(divLoad), .tick(pclkTick)
  );

  assign evtNext = evtCnt + CW'(evtInc);
  assign memWe   = strb.wrEvt | strb.wrMst;
  assign memAddr = wrPtr;
  assign memData = strb.wrEvt ? snapEvt : snapMst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtCnt      <= '0;
      mstCnt      <= '0;
      snapEvt     <= '0;
      snapMst     <= '0;
      idleCnt     <= '0;
      wrPtr       <= '0;
      timeoutFlag <= 1'b0;
    end else begin
      evtCnt <= evtNext;
      mstCnt <= mstCnt + CW'(1);
      if (strb.take) begin
        snapEvt <= evtNext;
        snapMst <= mstCnt;
      end
      if (memWe) wrPtr <= wrPtr + AW'(1);
      if (evtHit)                  idleCnt <= '0;
      else if (idleCnt != IDLE_MAX) idleCnt <= idleCnt + CW'(1);
      timeoutFlag <= (timeoutFlag & ~toClear) | (idleCnt > toLimit);
    end
  end

  // R2: the event count holds in cycles without a selected event
  assert_evt_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !evtHit |=> $stable(evtCnt));
  // R4: the master word lands one address above the event word
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEvt |=> (memAddr == $past(memAddr) + AW'(1)));
  // R8: the flag is sticky until cleared
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !toClear) |=> timeoutFlag);
endmodule

// File: rtl/ts_point_gen.sv
module ts_point_gen
  import tspg_pkg::*;
#(
  parameter int CW = 32,
  parameter int FW = 16,
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    refSel,
  input  logic          validA,
  input  logic          lostA,
  input  logic          validB,
  input  logic          lostB,
  input  logic          altRef,
  input  logic [DW-1:0] decim,
  input  logic [CW-1:0] divInt,
  input  logic [FW-1:0] divFrac,
  input  logic          divLoad,
  input  logic [CW-1:0] toLimit,
  input  logic          toClear,
  output logic          pclkTick,
  output logic          timeoutFlag,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [CW-1:0] memData
);
  logic [1:0] evtInc;
  logic       evtHit;
  strobe_t    strb;

  tspg_ctrl #(.DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .refSel(refSel),
    .validA(validA), .lostA(lostA), .validB(validB), .lostB(lostB),
    .altRef(altRef), .pclkTick(pclkTick), .decim(decim),
    .evtInc(evtInc), .evtHit(evtHit), .strb(strb)
  );

  tspg_datapath #(.CW(CW), .FW(FW), .AW(AW)) uData (
    .clk(clk), .rstN(rstN), .evtInc(evtInc), .evtHit(evtHit), .strb(strb),
    .divInt(divInt), .divFrac(divFrac), .divLoad(divLoad),
    .toLimit(toLimit), .toClear(toClear),
    .pclkTick(pclkTick), .timeoutFlag(timeoutFlag),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  // R9: no write in the first cycle after reset
  assert_reset_quiet_R9: assert property (@(posedge clk)
    $rose(rstN) |-> !memWe);
endmodule

// File: tb/sim_ts_point_gen.sv
module sim_ts_point_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  refSel = 2'd0;
  logic        validA = 0, lostA = 0, validB = 0, lostB = 0, altRef = 0;
  logic [15:0] decim = 16'd1;
  logic [31:0] divInt = 0;
  logic [15:0] divFrac = 0;
  logic        divLoad = 0;
  logic [31:0] toLimit = 32'hFFFF_FFFF;
  logic        toClear = 0;
  logic        pclkTick, timeoutFlag, memWe;
  logic [3:0]  memAddr;
  logic [31:0] memData;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] cyc;
  logic [3:0]  logA [0:255];
  logic [31:0] logD [0:255];
  int nLog = 0;
  logic [31:0] expEvt = 0;
  logic [3:0]  expPtr = 0;

  ts_point_gen u0 (.*);

  always #10 clk = ~clk;

  always @(posedge clk) if (!rstN) cyc <= 0; else cyc <= cyc + 1;

  always @(negedge clk) if (rstN && memWe && nLog < 256) begin
    logA[nLog] = memAddr; logD[nLog] = memData; nLog++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expectPoint(input string tag, input int base, input logic [31:0] e, input logic [31:0] m);
    chk(logD[base] == e, {tag, " R4 event word"}, logD[base], e);
    chk(logD[base+1] == m, {tag, " R3 master word"}, logD[base+1], m);
    chk(logA[base] == expPtr && logA[base+1] == expPtr + 4'd1, {tag, " R4 address/wrap"}, {28'd0, logA[base]}, {28'd0, expPtr});
    expPtr = expPtr + 4'd2;
  endtask

  // one-cycle pulse {vA,lA,vB,lB}; returns master count of the event cycle
  task automatic pulse(input logic [3:0] p, output logic [31:0] mAt);
    @(negedge clk);
    {validA, lostA, validB, lostB} = p;
    mAt = cyc;
    @(negedge clk);
    {validA, lostA, validB, lostB} = 4'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulsePoint(input string tag, input logic [3:0] p, input int inc);
    logic [31:0] m; int base;
    base = nLog;
    pulse(p, m);
    expEvt = expEvt + inc;
    chk(nLog == base + 2, {tag, " R4 two words"}, nLog, base + 2);
    expectPoint(tag, base, expEvt, m);
  endtask

  task automatic testReset;
    @(negedge clk);
    chk(!memWe, "R9 memWe", memWe, 0);
    chk(!pclkTick, "R9 pclkTick", pclkTick, 0);
    chk(!timeoutFlag, "R9 timeoutFlag", timeoutFlag, 0);
  endtask

  task automatic testChanA;
    logic [31:0] m1, m2; int base;
    refSel = 2'd0;
    base = nLog; pulse(4'b1000, m1); expEvt++;
    expectPoint("R1 chA first", base, expEvt, m1);
    repeat (5) @(negedge clk);
    base = nLog; pulse(4'b1000, m2); expEvt++;
    expectPoint("R1 chA second", base, expEvt, m2);
    chk(logD[base+1] - logD[base-1] == m2 - m1, "R3 master gap", logD[base+1] - logD[base-1], m2 - m1);
  endtask

  task automatic testLost;
    pulsePoint("R2 valid+lost", 4'b1100, 2);
    pulsePoint("R2 lost only", 4'b0100, 1);
  endtask

  task automatic testChanB;
    logic [31:0] m; int base;
    refSel = 2'd1;
    base = nLog; pulse(4'b1100, m);
    chk(nLog == base, "R1 unselected chA gives no point", nLog, base);
    pulsePoint("R1 chB after ignored chA", 4'b0010, 1);
  endtask

  task automatic testDecim;
    logic [31:0] m; int base;
    decim = 16'd3;
    for (int i = 1; i <= 5; i++) begin
      base = nLog; pulse(4'b0010, m); expEvt++;
      if (i == 3) begin
        chk(nLog == base + 2, "R5 third event kept", nLog, base + 2);
        expectPoint("R5 decimated", base, expEvt, m);
      end else chk(nLog == base, "R5 event skipped", nLog, base);
    end
    decim = 16'd0;
    pulsePoint("R5 decim zero keeps all", 4'b0010, 1);
    decim = 16'd1;
  endtask

  task automatic testDrop;
    logic [31:0] m; int base;
    base = nLog;
    @(negedge clk); validB = 1; m = cyc;
    repeat (3) @(negedge clk);
    validB = 0;
    repeat (4) @(negedge clk);
    chk(nLog == base + 4, "R6 two points from three events", nLog, base + 4);
    expectPoint("R6 first", base, expEvt + 1, m);
    expectPoint("R6 after drop", base + 2, expEvt + 3, m + 2);
    expEvt = expEvt + 3;
  endtask

  task automatic testAlt;
    logic [31:0] m; int base;
    refSel = 2'd2;
    for (int r = 0; r < 2; r++) begin
      base = nLog;
      @(negedge clk); altRef = 1; m = cyc;
      repeat (4) @(negedge clk);
      altRef = 0;
      repeat (3) @(negedge clk);
      expEvt++;
      chk(nLog == base + 2, "R10 one point per rising edge", nLog, base + 2);
      expectPoint("R10 alt edge", base, expEvt, m);
    end
  endtask

  task automatic testDivider;
    int pos[5]; int n; int exp5[5]; logic [31:0] m; int base;
    exp5 = '{3, 7, 12, 16, 21};
    n = 0;
    repeat (10) @(negedge clk) if (pclkTick) n++;
    chk(n == 0, "R7 no tick before load", n, 0);
    @(negedge clk); divInt = 4; divFrac = 16'h8000; divLoad = 1;
    @(negedge clk); divLoad = 0;
    n = 0;
    for (int e = 1; e <= 21; e++) begin
      @(negedge clk);
      if (pclkTick && n < 5) begin pos[n] = e; n++; end
    end
    chk(n == 5, "R7 tick count", n, 5);
    for (int i = 0; i < 5; i++) chk(pos[i] == exp5[i], "R7 tick position", pos[i], exp5[i]);
    // precise tick as reference
    @(negedge clk); divInt = 6; divFrac = 0; divLoad = 1;
    @(negedge clk); divLoad = 0; refSel = 2'd3;
    base = nLog;
    while (!pclkTick) @(negedge clk);
    m = cyc;
    @(negedge clk); refSel = 2'd1;
    repeat (2) @(negedge clk);
    expEvt++;
    chk(nLog == base + 2, "R1 precise tick reference", nLog, base + 2);
    expectPoint("R1 tick point", base, expEvt, m);
  endtask

  task automatic testTimeout;
    toLimit = 32'd10;
    @(negedge clk); validB = 1;
    @(negedge clk); validB = 0; toClear = 1;
    @(negedge clk); toClear = 0;
    chk(!timeoutFlag, "R8 cleared", timeoutFlag, 0);
    for (int i = 2; i <= 11; i++) begin
      @(negedge clk);
      if (i == 11) chk(!timeoutFlag, "R8 not yet at limit", timeoutFlag, 0);
    end
    @(negedge clk);
    chk(timeoutFlag, "R8 fires after limit", timeoutFlag, 1);
    expEvt++; expPtr = expPtr + 4'd2;
    pulsePoint("R8 event after timeout", 4'b0010, 1);
    chk(timeoutFlag, "R8 sticky across event", timeoutFlag, 1);
    toLimit = 32'hFFFF_FFFF;
    @(negedge clk); toClear = 1;
    @(negedge clk); toClear = 0;
    chk(!timeoutFlag, "R8 clear", timeoutFlag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testChanA();
    testLost();
    testChanB();
    testDecim();
    testDrop();
    testAlt();
    testDivider();
    testTimeout();
    repeat (3) @(negedge clk);
    chk(expPtr == logA[nLog-2] + 4'd2, "R4 pointer after wrap", {28'd0, expPtr}, {28'd0, logA[nLog-2] + 4'd2});
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule